// File: doc/BRIEF.md
# Command-Word Serial Management Master

This block runs clause-22 management frames toward an external PHY. One 32-bit command/status word, sitting on a plain write-strobe and read-data register interface, controls it. Software writes a single word that packs a go flag, a direction flag, the 5-bit PHY address, the 5-bit register number and 16 data bits. The block then generates the management clock from the system clock and shifts the complete frame out on the data pin. For reads, it turns the pin around and shifts the answer back in.

The go flag is also the busy indication. It stays set while the frame is on the wire and drops on its own when the last bit time has ended. After a read, the 16 bits returned by the PHY replace the low half of the same word. Software therefore polls one location both to learn that the block is free and to pick up read results. A write that arrives while a frame is running is dropped.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the management clock is low, the data pin is not driven (`mdio_oe` = 0) and the command word reads as all zeros.
- R2: Writing a word with bit 31 set while idle starts a frame. Bit 31 reads back as 1 until the 64th bit time of the frame has ended, and then reads 0.
- R3: Every frame starts with 32 one bits, then 0,1, then the opcode (0,1 when bit 30 is clear for a write; 1,0 when bit 30 is set for a read), then bits 25:21 and then bits 20:16 of the word, each MSB first.
- R4: In a write frame the master drives the pin for all 64 bit times. Turnaround is 1 then 0, followed by bits 15:0 MSB first. When the frame ends, the word equals the written word with bit 31 cleared.
- R5: In a read frame the master releases the pin from the first turnaround bit to the end of the frame. It samples 16 bits on rising clock edges, MSB first, into bits 15:0. Bits 30:16 keep their written values and bit 31 clears.
- R6: A register write that arrives while bit 31 reads 1 has no effect on the running frame or on the word.
- R7: While a frame runs, each management clock half period lasts DIV_HALF system clocks. Between frames the clock stays low.
- R8: The data output and its enable change only at falling management clock edges (or at frame start and end), never while the clock is high.
- R9: Writing a word with bit 31 clear stores it in the register and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven toward the PHY |
| mdio_oe | output | 1 | Data pin drive enable (1 = master drives) |
| mdio_i | input | 1 | Data value seen on the pin |

## Verification
Two situations are hard to reach. The first is a write that lands in the middle of a running frame. The second is the exact moment the pin is handed over during a read turnaround. The bench issues colliding writes at a fixed cycle within the frame, using a word whose every field differs, and then checks that the captured frame and the final word belong only to the first command. A PHY model counts rising management clock edges and drives reply bits after falling edges. It records, per bit time, both the pin value and the drive enable, so the release point is compared bit by bit.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_BITS    = 64;
  localparam int PREAMBLE_BITS = 32;
  localparam int TA_FIRST      = 46;
  localparam int DATA_FIRST    = 48;
  localparam int IDX_W         = $clog2(FRAME_BITS);

  // Field layout of the command word; software depends on these positions.
  typedef struct packed {
    logic        go;     // bit 31: request / busy
    logic        rd;     // bit 30: 1 = read, 0 = write
    logic [3:0]  spare;  // bits 29:26
    logic [4:0]  phy;    // bits 25:21
    logic [4:0]  regn;   // bits 20:16
    logic [15:0] data;   // bits 15:0
  } cmd_word_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_p,
  output logic fall_p
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick   = run && (cnt_q == LAST);
  assign rise_p = tick && !mdc_q;
  assign fall_p = tick && mdc_q;
  assign mdc    = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc_q); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  start_phy,
  input  logic [4:0]  start_reg,
  input  logic [15:0] start_wdata,
  input  logic        rise_p,
  input  logic        fall_p,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PREAMBLE_BITS);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      tx_q, tx_d;
  logic [15:0]      rx_q, rx_d;

  assign done    = busy_q && fall_p && (idx_q == LAST_IDX);
  assign busy    = busy_q;
  assign rx_data = rx_q;
  assign mdio_o  = busy_q && ((idx_q < PRE_END) || tx_q[31]);
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= TA_IDX));

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = start_rd;
      idx_d  = '0;
      tx_d   = {2'b01, (start_rd ? 2'b10 : 2'b01), start_phy, start_reg,
                (start_rd ? 2'b00 : 2'b10), (start_rd ? 16'h0000 : start_wdata)};
      rx_d   = '0;
    end else if (busy_q) begin
      if (rise_p && rd_q && (idx_q >= DAT_IDX)) begin
        rx_d = {rx_q[14:0], mdio_i};
      end
      if (fall_p) begin
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          if (idx_q >= PRE_END) begin
            tx_d = {tx_q[30:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe); // R1
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]  rst_sync_q;
  logic        rst_s_n;
  cmd_word_t   cmd_q, cmd_d, wr_word;
  logic        start;
  logic        eng_busy, eng_done;
  logic [15:0] eng_rx;
  logic        rise_p, fall_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign wr_word = cmd_word_t'(reg_wdata);

  always_comb begin
    cmd_d = cmd_q;
    start = 1'b0;
    if (eng_done) begin
      cmd_d.go = 1'b0;
      if (cmd_q.rd) cmd_d.data = eng_rx;
    end else if (reg_wr && !cmd_q.go) begin
      cmd_d = wr_word;
      start = wr_word.go;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cmd_q <= '0;
    else          cmd_q <= cmd_d;
  end

  assign reg_rdata = cmd_q;

  mdio_mdc_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run    (eng_busy),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_frame_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start),
    .start_rd    (wr_word.rd),
    .start_phy   (wr_word.phy),
    .start_reg   (wr_word.regn),
    .start_wdata (wr_word.data),
    .rise_p      (rise_p),
    .fall_p      (fall_p),
    .mdio_i      (mdio_i),
    .busy        (eng_busy),
    .done        (eng_done),
    .rx_data     (eng_rx),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
  );

  AST_GO_TRACKS_FRAME: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_q.go == eng_busy); // R2
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_q.go && reg_wr && !eng_done) |=> ($stable(cmd_q[30:0]) && cmd_q.go)); // R6
  AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($fell(mdio_oe) && cmd_q.go) |-> cmd_q.rd); // R5
  AST_PIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
endmodule

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
  localparam int CLK_PERIOD = 10;
  localparam int DH = 2;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  mdio_cmd_master #(.DIV_HALF(DH)) i_mdio_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: records each bit time at the rising edge, answers after falling edges
  logic        prev_mdc = 1'b0;
  int          rise_cnt = 0;
  int          per_bad = 0;
  int          last_rise = 0;
  logic [63:0] cap, capoe;
  logic [15:0] reply;

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (rise_cnt < 64) begin
        cap[63-rise_cnt]   = mdio_o;
        capoe[63-rise_cnt] = mdio_oe;
      end
      if (rise_cnt > 0 && (cyc - last_rise) != 2*DH) per_bad++;
      last_rise = cyc;
      rise_cnt++;
    end
    if (!mdc && prev_mdc) begin
      if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = reply[63-rise_cnt];
      else mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [31:0] word, input logic [15:0] rep, input bit collide);
    logic [63:0] exp;
    logic [31:0] exp_reg;
    bit rd;
    int n;
    rd = word[30];
    rise_cnt = 0; per_bad = 0; cap = '0; capoe = '0; reply = rep;
    reg_wdata = word; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    n = 0;
    while (reg_rdata[31] && n < 4000) begin
      if (collide && n == 50) begin
        reg_wr = 1'b1; reg_wdata = ~word | 32'h8000_0000;
      end else begin
        reg_wr = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    check(rise_cnt == 64, "R2 busy until frame end (rises)", 64'(rise_cnt), 64'd64);
    exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), word[25:21], word[20:16],
           (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : word[15:0])};
    if (rd) begin
      check(cap[63:18] == exp[63:18], "R3 read header", cap, exp);
      check(capoe == {{46{1'b1}}, 18'h0}, "R5 read release", capoe, {{46{1'b1}}, 18'h0});
      exp_reg = {1'b0, word[30:16], rep};
      check(reg_rdata == exp_reg, collide ? "R6 R5 read result" : "R5 read result",
            64'(reg_rdata), 64'(exp_reg));
    end else begin
      check(cap == exp, "R3 R4 write frame", cap, exp);
      check(capoe == '1, "R4 write drive", capoe, '1);
      exp_reg = {1'b0, word[30:0]};
      check(reg_rdata == exp_reg, collide ? "R6 R4 write result" : "R4 write result",
            64'(reg_rdata), 64'(exp_reg));
    end
    check(per_bad == 0, "R7 mdc period", 64'(per_bad), 64'd0);
    check(!mdc && !mdio_oe, "R7 R1 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; mdio_i = 1'b1; reply = '0;
    repeat (4) @(negedge clk);
    check(reg_rdata == 32'h0 && !mdc && !mdio_oe, "R1 reset state",
          {reg_rdata, 30'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(reg_rdata == 32'h0 && !mdc && !mdio_oe, "R1 after reset release",
          {reg_rdata, 30'd0, mdc, mdio_oe}, 64'd0);

    // R9: word without the go bit is stored, no clock activity
    rise_cnt = 0;
    reg_wdata = 32'h7ABC_1234; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (40) @(negedge clk);
    check(rise_cnt == 0, "R9 no frame", 64'(rise_cnt), 64'd0);
    check(reg_rdata == 32'h7ABC_1234, "R9 stored", 64'(reg_rdata), 64'h7ABC_1234);

    for (int i = 0; i < 12; i++) begin
      logic [31:0] w;
      logic [4:0]  phy;
      logic [4:0]  rg;
      phy = (i == 0) ? 5'd0 : (i == 1) ? 5'd31 : 5'((i * 13) % 32);
      rg  = 5'(31 - i * 3);
      w   = {1'b1, i[0], i[3:0], phy, rg, 16'hA5C3 ^ 16'(i * 16'h1111)};
      do_cmd(w, 16'(16'h5A3C + i * 16'h0F0F), (i == 4 || i == 7));
      repeat (3) @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule